// File: doc/BRIEF.md
# Dual-Buffer Receive DMA with First-Error Offset Capture

This block drains a serial receiver's character FIFO into memory. Each FIFO entry holds a data byte together with a parity-error flag and a framing-error flag. The engine writes the characters one by one through a valid/ready memory write port into two alternating buffers, A and B. Each buffer is given a base address and a length. When one buffer fills, the engine moves on to the other one. If that buffer has not been armed, the engine waits until it is.

As the characters go out, the engine inspects their error flags. For each buffer it keeps the byte offset of the first character that arrived with a parity or framing fault. A receive overrun reported by the FIFO is also logged in that same per-buffer slot. Its offset is the position where the first character following the lost ones will land. An overrun also produces an interrupt pulse and a sticky status flag at once, without waiting for the transfer to reach that position. Software re-arms a drained buffer by loading it again, and the load clears its error record.

Top module: `rx_err_dma`

## Requirements
- R1: During and after synchronous reset, both buffers are not ready, both error records are invalid with offset 0, the overrun interrupt and flag are low, the active buffer is A (`act_buf`=0) and `mem_valid` and `fifo_pop` are low.
- R2: A pulse on `load_a` or `load_b` is accepted only if that buffer is not ready and `cfg_len` is non-zero. An accepted load captures `cfg_base` and `cfg_len`, sets the buffer ready and clears its error record, all visible on the next cycle. A load that is refused changes nothing.
- R3: While the active buffer is ready and `fifo_valid` is high, `mem_valid` is high in the same cycle, with `mem_data` equal to the FIFO byte. `fifo_pop` is high in exactly the cycles where `mem_valid` and `mem_ready` are both high.
- R4: The offset starts at 0 for the first character of a buffer and goes up by one per accepted write. `mem_addr` equals the buffer base plus the offset.
- R5: The write accepted at offset length−1 clears that buffer's ready bit, switches `act_buf` to the other buffer and resets the offset to 0.
- R6: While the active buffer is not ready, `mem_valid` and `fifo_pop` stay low whatever the FIFO holds. Transfer resumes once that buffer is loaded.
- R7: When an accepted character has parity or framing error set and the active buffer's error record is invalid, the record becomes valid on the next cycle with the character's offset. A character that is not accepted records nothing.
- R8: Once a buffer's record is valid, later line errors and overruns leave it unchanged until that buffer is reloaded.
- R9: On an `ovf_event` cycle, if the active buffer is ready and its record is invalid, the record becomes valid next cycle with offset = current offset + `fifo_level` (modulo 2^8). A line error accepted in the same cycle takes precedence.
- R10: `ovf_irq` is high for the cycle after each `ovf_event`. `ovf_flag` rises the cycle after an `ovf_event` and stays high until a load is accepted; an event in the same cycle as the load wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_a | input | 1 | Arm buffer A with cfg_base/cfg_len |
| load_b | input | 1 | Arm buffer B with cfg_base/cfg_len |
| cfg_base | input | 16 | Base address for a load |
| cfg_len | input | 8 | Buffer length in characters for a load |
| fifo_valid | input | 1 | FIFO holds at least one character |
| fifo_data | input | 8 | Head character byte |
| fifo_perr | input | 1 | Head character parity error |
| fifo_ferr | input | 1 | Head character framing error |
| fifo_level | input | 5 | Characters currently held in the FIFO |
| fifo_pop | output | 1 | Remove head character |
| ovf_event | input | 1 | FIFO overrun pulse |
| mem_valid | output | 1 | Write request valid |
| mem_addr | output | 16 | Write byte address |
| mem_data | output | 8 | Write byte |
| mem_ready | input | 1 | Memory accepts the write |
| rdy_a | output | 1 | Buffer A armed |
| rdy_b | output | 1 | Buffer B armed |
| err_vld_a | output | 1 | Buffer A error offset valid |
| err_off_a | output | 8 | Buffer A first error offset |
| err_vld_b | output | 1 | Buffer B error offset valid |
| err_off_b | output | 8 | Buffer B first error offset |
| act_buf | output | 1 | Active buffer (0 = A, 1 = B) |
| ovf_irq | output | 1 | Overrun interrupt pulse |
| ovf_flag | output | 1 | Sticky overrun status |

## Verification
The write request, address, data and pop are combinational and are due in the same cycle that the FIFO and ready inputs present them. Buffer ready bits, error records, the active buffer, the offset, the interrupt and the flag all change one clock edge after the event that causes them. The reference model therefore compares the combinational outputs against its state at each falling edge. It then advances its own state using the inputs held at that edge, which the next rising edge also samples. Directed checks read registered results one cycle after a pulse, shortly after the rising edge.

// File: rtl/rxdma_pkg.sv
package rxdma_pkg;
    parameter int ADDR_W = 16;
    parameter int LEN_W  = 8;
    parameter int DATA_W = 8;
    parameter int LVL_W  = 5;
    parameter int NBUF   = 2;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [LEN_W-1:0]  off_t;
    typedef logic [LVL_W-1:0]  lvl_t;

    typedef enum logic { BUF_A = 1'b0, BUF_B = 1'b1 } buf_sel_t;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              perr;
        logic              ferr;
    } rx_char_t;

    typedef struct packed {
        addr_t base;
        off_t  len;
        logic  rdy;
    } chan_cfg_t;

    typedef struct packed {
        logic vld;
        off_t off;
    } err_rec_t;

    function automatic logic char_bad(rx_char_t c);
        return c.perr | c.ferr;
    endfunction

    function automatic off_t ovf_pos(off_t cur, lvl_t lvl);
        return off_t'(cur + off_t'(lvl));
    endfunction

    function automatic buf_sel_t other_buf(buf_sel_t b);
        return (b == BUF_A) ? BUF_B : BUF_A;
    endfunction
endpackage

// File: rtl/rxdma_chan.sv
module rxdma_chan
    import rxdma_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      load,
    input  addr_t     base_in,
    input  off_t      len_in,
    input  logic      consume,
    input  logic      last,
    input  logic      line_err,
    input  logic      ovf_hit,
    input  off_t      cur_off,
    input  off_t      ovf_off,
    output logic      load_acc,
    output chan_cfg_t cfg,
    output err_rec_t  err
);
    assign load_acc = load && !cfg.rdy && (len_in != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (load_acc) begin
            cfg.base <= base_in;
            cfg.len  <= len_in;
            cfg.rdy  <= 1'b1;
        end else if (consume && last) begin
            cfg.rdy  <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            err <= '0;
        end else if (load_acc) begin
            err <= '0;
        end else if (!err.vld) begin
            if (consume && line_err) begin
                err.vld <= 1'b1;
                err.off <= cur_off;
            end else if (ovf_hit) begin
                err.vld <= 1'b1;
                err.off <= ovf_off;
            end
        end
    end

    // R7
    first_line_err_chk: assert property (@(posedge clk) disable iff (rst)
        (consume && line_err && !err.vld) |=> (err.vld && err.off == $past(cur_off)));

    // R8
    hold_err_chk: assert property (@(posedge clk) disable iff (rst)
        (err.vld && !load_acc) |=> $stable(err));
endmodule

// File: rtl/rxdma_seq.sv
module rxdma_seq
    import rxdma_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  chan_cfg_t cfg_a,
    input  chan_cfg_t cfg_b,
    input  logic      fifo_valid,
    input  logic      mem_ready,
    output buf_sel_t  act,
    output off_t      off,
    output logic      act_rdy,
    output logic      mem_valid,
    output addr_t     mem_addr,
    output logic      pop,
    output logic      last
);
    chan_cfg_t cur;

    always_comb begin
        cur       = (act == BUF_A) ? cfg_a : cfg_b;
        act_rdy   = cur.rdy;
        mem_valid = act_rdy && fifo_valid;
        mem_addr  = addr_t'(cur.base + addr_t'(off));
        pop       = mem_valid && mem_ready;
        last      = (off == off_t'(cur.len - 1'b1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act <= BUF_A;
            off <= '0;
        end else if (pop) begin
            if (last) begin
                act <= other_buf(act);
                off <= '0;
            end else begin
                off <= off_t'(off + 1'b1);
            end
        end
    end

    // R4
    off_step_chk: assert property (@(posedge clk) disable iff (rst)
        (pop && !last) |=> (off == off_t'($past(off) + 1'b1)));

    // R5
    buf_switch_chk: assert property (@(posedge clk) disable iff (rst)
        (pop && last) |=> (off == '0 && act != $past(act)));
endmodule

// File: rtl/rxdma_ovf.sv
module rxdma_ovf (
    input  logic clk,
    input  logic rst,
    input  logic ovf_event,
    input  logic any_load,
    output logic irq,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (rst) begin
            irq  <= 1'b0;
            flag <= 1'b0;
        end else begin
            irq <= ovf_event;
            if (ovf_event)     flag <= 1'b1;
            else if (any_load) flag <= 1'b0;
        end
    end

    // R10
    ovf_signal_chk: assert property (@(posedge clk) disable iff (rst)
        ovf_event |=> (irq && flag));
endmodule

// File: rtl/rx_err_dma.sv
module rx_err_dma
    import rxdma_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load_a,
    input  logic              load_b,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [LEN_W-1:0]  cfg_len,
    input  logic              fifo_valid,
    input  logic [DATA_W-1:0] fifo_data,
    input  logic              fifo_perr,
    input  logic              fifo_ferr,
    input  logic [LVL_W-1:0]  fifo_level,
    output logic              fifo_pop,
    input  logic              ovf_event,
    output logic              mem_valid,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_data,
    input  logic              mem_ready,
    output logic              rdy_a,
    output logic              rdy_b,
    output logic              err_vld_a,
    output logic [LEN_W-1:0]  err_off_a,
    output logic              err_vld_b,
    output logic [LEN_W-1:0]  err_off_b,
    output logic              act_buf,
    output logic              ovf_irq,
    output logic              ovf_flag
);
    rx_char_t  head;
    chan_cfg_t cfg      [NBUF];
    err_rec_t  err      [NBUF];
    logic      load_acc [NBUF];
    logic      load_req [NBUF];
    buf_sel_t  act;
    off_t      off;
    logic      act_rdy, pop, last, bad;
    off_t      ovf_off;

    assign head     = '{data: fifo_data, perr: fifo_perr, ferr: fifo_ferr};
    assign bad      = char_bad(head);
    assign ovf_off  = ovf_pos(off, lvl_t'(fifo_level));
    assign load_req[0] = load_a;
    assign load_req[1] = load_b;

    rxdma_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .cfg_a     (cfg[0]),
        .cfg_b     (cfg[1]),
        .fifo_valid(fifo_valid),
        .mem_ready (mem_ready),
        .act       (act),
        .off       (off),
        .act_rdy   (act_rdy),
        .mem_valid (mem_valid),
        .mem_addr  (mem_addr),
        .pop       (pop),
        .last      (last)
    );

    for (genvar i = 0; i < NBUF; i++) begin : g_chan
        logic sel;
        assign sel = (act == buf_sel_t'(i));
        rxdma_chan u_chan (
            .clk     (clk),
            .rst     (rst),
            .load    (load_req[i]),
            .base_in (cfg_base),
            .len_in  (cfg_len),
            .consume (pop && sel),
            .last    (last),
            .line_err(bad),
            .ovf_hit (ovf_event && sel && act_rdy),
            .cur_off (off),
            .ovf_off (ovf_off),
            .load_acc(load_acc[i]),
            .cfg     (cfg[i]),
            .err     (err[i])
        );
    end

    rxdma_ovf u_ovf (
        .clk      (clk),
        .rst      (rst),
        .ovf_event(ovf_event),
        .any_load (load_acc[0] || load_acc[1]),
        .irq      (ovf_irq),
        .flag     (ovf_flag)
    );

    assign fifo_pop  = pop;
    assign mem_data  = head.data;
    assign rdy_a     = cfg[0].rdy;
    assign rdy_b     = cfg[1].rdy;
    assign err_vld_a = err[0].vld;
    assign err_off_a = err[0].off;
    assign err_vld_b = err[1].vld;
    assign err_off_b = err[1].off;
    assign act_buf   = act;

    // R6
    stall_chk: assert property (@(posedge clk) disable iff (rst)
        ((act == BUF_A && !rdy_a) || (act == BUF_B && !rdy_b)) |-> !fifo_pop);

    // R2
    load_arm_chk: assert property (@(posedge clk) disable iff (rst)
        (load_a && !rdy_a && cfg_len != '0) |=> (rdy_a && !err_vld_a));
endmodule

// File: tb/sim_rx_err_dma.sv
module sim_rx_err_dma;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        load_a = 0, load_b = 0;
    logic [15:0] cfg_base = '0;
    logic [7:0]  cfg_len = '0;
    logic        fifo_valid = 0;
    logic [7:0]  fifo_data = '0;
    logic        fifo_perr = 0, fifo_ferr = 0;
    logic [4:0]  fifo_level = '0;
    logic        fifo_pop;
    logic        ovf_event = 0;
    logic        mem_valid;
    logic [15:0] mem_addr;
    logic [7:0]  mem_data;
    logic        mem_ready = 1;
    logic        rdy_a, rdy_b, err_vld_a, err_vld_b, act_buf, ovf_irq, ovf_flag;
    logic [7:0]  err_off_a, err_off_b;

    always #4 clk = ~clk;

    rx_err_dma u0 (.*);

    typedef struct { logic [7:0] d; logic p; logic f; } ch_t;
    ch_t q[$];
    bit  pop_pending = 0;
    bit  toggle_rdy = 0;
    int  n_tests = 0, n_fail = 0;
    int  cyc = 0;
    bit  done = 0;
    logic [15:0] wlog[$];

    bit          m_rdy[2];
    logic [15:0] m_base[2];
    logic [7:0]  m_len[2];
    bit          m_ev[2];
    logic [7:0]  m_eo[2];
    int          m_act;
    logic [7:0]  m_off;
    bit          m_irq, m_flag;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic m_reset();
        for (int i = 0; i < 2; i++) begin
            m_rdy[i] = 0; m_base[i] = '0; m_len[i] = '0; m_ev[i] = 0; m_eo[i] = '0;
        end
        m_act = 0; m_off = '0; m_irq = 0; m_flag = 0;
    endtask

    task automatic refresh();
        fifo_valid = (q.size() > 0);
        fifo_level = 5'(q.size());
        if (q.size() > 0) begin
            fifo_data = q[0].d; fifo_perr = q[0].p; fifo_ferr = q[0].f;
        end else begin
            fifo_data = '0; fifo_perr = 0; fifo_ferr = 0;
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        cyc++;
        if (pop_pending) begin
            void'(q.pop_front());
            pop_pending = 0;
        end
        if (toggle_rdy) mem_ready = ~mem_ready;
        refresh();
    endtask

    task automatic push(input logic [7:0] d, input bit p, input bit f);
        ch_t c;
        c.d = d; c.p = p; c.f = f;
        q.push_back(c);
        refresh();
    endtask

    task automatic do_load(input bit b, input logic [15:0] base, input logic [7:0] len);
        cfg_base = base; cfg_len = len;
        if (b) load_b = 1; else load_a = 1;
        tick();
        load_a = 0; load_b = 0;
    endtask

    task automatic drain();
        for (int k = 0; k < 200 && (q.size() > 0 || pop_pending); k++) tick();
        tick();
    endtask

    initial m_reset();

    // cycle reference model: compare at falling edge, then advance
    always @(negedge clk) begin
        bit          vr, e_pop, lst, bad;
        bit          la[2];
        logic [7:0]  lvl;
        logic [15:0] e_addr;
        if (!rst) begin
            vr     = m_rdy[m_act];
            e_pop  = vr && (q.size() > 0) && mem_ready;
            e_addr = m_base[m_act] + 16'(m_off);
            chk(mem_valid == (vr && q.size() > 0), "R3/R6 mem_valid", mem_valid, vr && q.size() > 0);
            chk(fifo_pop == e_pop, "R3 fifo_pop", fifo_pop, e_pop);
            if (vr && q.size() > 0) begin
                chk(mem_addr == e_addr, "R4 mem_addr", mem_addr, e_addr);
                chk(mem_data == q[0].d, "R3 mem_data", mem_data, q[0].d);
            end
            chk(rdy_a == m_rdy[0] && rdy_b == m_rdy[1], "R2/R5 ready", {rdy_b, rdy_a}, {m_rdy[1], m_rdy[0]});
            chk(act_buf == m_act[0], "R5 act_buf", act_buf, m_act);
            chk(err_vld_a == m_ev[0] && err_off_a == m_eo[0], "R7/R9 err A",
                {err_vld_a, err_off_a}, {m_ev[0], m_eo[0]});
            chk(err_vld_b == m_ev[1] && err_off_b == m_eo[1], "R7/R9 err B",
                {err_vld_b, err_off_b}, {m_ev[1], m_eo[1]});
            chk(ovf_irq == m_irq && ovf_flag == m_flag, "R10 ovf", {ovf_irq, ovf_flag}, {m_irq, m_flag});
            if (e_pop) wlog.push_back(mem_addr);
            // next state
            lst = (m_off == 8'(m_len[m_act] - 8'd1));
            bad = (q.size() > 0) && (q[0].p || q[0].f);
            lvl = 8'(q.size());
            la[0] = load_a && !m_rdy[0] && cfg_len != 0;
            la[1] = load_b && !m_rdy[1] && cfg_len != 0;
            for (int i = 0; i < 2; i++) begin
                if (la[i]) begin
                    m_rdy[i] = 1; m_base[i] = cfg_base; m_len[i] = cfg_len; m_ev[i] = 0; m_eo[i] = '0;
                end else if (i == m_act) begin
                    if (!m_ev[i]) begin
                        if (e_pop && bad) begin m_ev[i] = 1; m_eo[i] = m_off; end
                        else if (ovf_event && vr) begin m_ev[i] = 1; m_eo[i] = 8'(m_off + lvl); end
                    end
                    if (e_pop && lst) m_rdy[i] = 0;
                end
            end
            if (e_pop) begin
                if (lst) begin m_off = '0; m_act = 1 - m_act; end
                else m_off = m_off + 8'd1;
            end
            m_irq = ovf_event;
            if (ovf_event) m_flag = 1;
            else if (la[0] || la[1]) m_flag = 0;
            pop_pending = e_pop;
        end else begin
            m_reset();
        end
    end

    initial begin
        for (int w = 0; w < 20000 && !done; w++) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        refresh();
        for (int i = 0; i < 3; i++) tick();
        rst = 0;
        tick();
        // R1 reset state
        chk(!rdy_a && !rdy_b && !err_vld_a && !err_vld_b && err_off_a == 0, "R1 reset regs",
            {rdy_a, rdy_b, err_vld_a, err_vld_b}, 0);
        chk(!mem_valid && !fifo_pop && !ovf_irq && !ovf_flag && act_buf == 0, "R1 reset outputs",
            {mem_valid, fifo_pop, ovf_irq, ovf_flag, act_buf}, 0);

        // Two buffers, errors in each, memory with back-pressure
        do_load(0, 16'h0100, 8'd4);
        do_load(1, 16'h0200, 8'd3);
        toggle_rdy = 1;
        push(8'h10, 0, 0); push(8'h11, 1, 0); push(8'h12, 0, 1); push(8'h13, 0, 0);
        push(8'h20, 0, 0); push(8'h21, 0, 1); push(8'h22, 1, 0);
        drain();
        toggle_rdy = 0; mem_ready = 1;
        chk(err_vld_a && err_off_a == 8'd1, "R7 first error A offset", err_off_a, 1);
        chk(err_vld_b && err_off_b == 8'd1, "R8 first error B kept", err_off_b, 1);
        chk(!rdy_a && !rdy_b && act_buf == 0, "R5 both buffers consumed", {rdy_a, rdy_b, act_buf}, 0);
        chk(wlog.size() == 7, "R4 write count", wlog.size(), 7);
        if (wlog.size() == 7) begin
            chk(wlog[0] == 16'h0100 && wlog[3] == 16'h0103, "R4 A addresses", wlog[3], 16'h0103);
            chk(wlog[4] == 16'h0200 && wlog[6] == 16'h0202, "R5 B addresses", wlog[6], 16'h0202);
        end

        // Stall with no ready buffer
        push(8'h30, 0, 0);
        for (int i = 0; i < 5; i++) tick();
        chk(!mem_valid && !fifo_pop, "R6 stall while unarmed", {mem_valid, fifo_pop}, 0);
        do_load(0, 16'h0300, 8'd6);
        chk(!err_vld_a && rdy_a, "R2 load clears record", {rdy_a, err_vld_a}, 2'b10);
        chk(mem_valid && mem_addr == 16'h0300, "R6 resumes at base", mem_addr, 16'h0300);
        drain();

        // Overrun with three characters queued at offset 1
        mem_ready = 0;
        push(8'h40, 0, 0); push(8'h41, 0, 0); push(8'h42, 0, 0);
        ovf_event = 1;
        tick();
        ovf_event = 0;
        chk(ovf_irq && ovf_flag, "R10 irq and flag", {ovf_irq, ovf_flag}, 2'b11);
        chk(err_vld_a && err_off_a == 8'd4, "R9 overrun offset", err_off_a, 4);
        tick();
        chk(!ovf_irq && ovf_flag, "R10 pulse ends, flag sticky", {ovf_irq, ovf_flag}, 2'b01);
        mem_ready = 1;
        push(8'h43, 1, 0);
        drain();
        chk(err_off_a == 8'd4, "R8 later error ignored", err_off_a, 4);

        // Refused loads
        do_load(0, 16'h0500, 8'd9);
        chk(err_vld_a && err_off_a == 8'd4 && ovf_flag, "R2 load on ready buffer ignored",
            {err_vld_a, ovf_flag}, 2'b11);
        push(8'h50, 0, 0);
        tick();
        chk(wlog[wlog.size()-1] == 16'h0305, "R2 base unchanged", wlog[wlog.size()-1], 16'h0305);
        do_load(1, 16'h0600, 8'd0);
        chk(!rdy_b && ovf_flag, "R2 zero length refused", {rdy_b, ovf_flag}, 2'b01);
        do_load(1, 16'h0600, 8'd2);
        chk(rdy_b && !ovf_flag, "R10 flag cleared by load", {rdy_b, ovf_flag}, 2'b10);

        // Error and overrun in the same cycle on B
        push(8'h60, 0, 1); push(8'h61, 0, 0);
        ovf_event = 1;
        tick();
        ovf_event = 0;
        chk(err_vld_b && err_off_b == 8'd0, "R9 line error wins over overrun", err_off_b, 0);
        drain();
        for (int i = 0; i < 3; i++) tick();

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule